// File: doc/BRIEF.md
# Shadow-Reconfigurable Lookup Table

This block is an N-input lookup table whose truth table is held in two tiers. A background configuration store keeps two complete truth tables, called contexts. It can be written one bit per cycle at any time. A foreground working latch holds the table that is in use. Only the latch feeds the multiplexer tree that turns the LUT inputs into the output, so new content can be prepared in the store while the function keeps computing with the old one.

A single sense strobe copies the chosen context, in full, from the store into the latch. The context is chosen by a select input that is sampled together with the strobe. For a fixed two-cycle window after the strobe, the valid flag is low and the output must not be used. When the flag rises again, the latch matches the chosen context. The store is free to take further writes in every cycle, including during the window.

Top module: `shadow_lut`

## Requirements
- R1: While reset is held (synchronous, active low), `valid_o` is 0 and the latch is all zero, so `lut_o` is 0 for every input pattern. Reset does not clear the store.
- R2: `lut_o` equals bit `lut_in` of the latch. Bit index i is the table entry for input value i, with `lut_in[0]` as the least significant select.
- R3: A write to the store (`cfg_we`=1 writes `cfg_data` to bit `cfg_addr` of context `cfg_ctx` at the clock edge) leaves `lut_o` unchanged until a sense is accepted.
- R4: A sense accepted at an edge loads all 2^N bits of context `ctx_sel` (0 or 1, as sampled at that edge) into the latch in one step.
- R5: After the edge that accepts a sense, `valid_o` is 0 for exactly 2 cycles and is 1 from the third edge on.
- R6: A sense strobe that arrives while a sense is in progress is ignored. The latch keeps the first context, and `valid_o` returns at the time set by the first strobe.
- R7: When a write and an accepted sense hit the selected context at the same edge, the sense loads the value from before the write. The write still lands in the store and appears after the next sense.
- R8: A write to one context never alters the other context.
- R9: Writes made while a sense is in progress are stored and become visible at the next sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lut_in | input | N_IN | LUT select inputs |
| lut_o | output | 1 | LUT result taken from the working latch |
| cfg_we | input | 1 | Store write enable, one bit per cycle |
| cfg_ctx | input | 1 | Context addressed by the write |
| cfg_addr | input | N_IN | Table bit addressed by the write |
| cfg_data | input | 1 | Bit value to write |
| ctx_sel | input | 1 | Context that the next sense loads |
| sense_i | input | 1 | Sense strobe: copy the selected context into the latch |
| valid_o | output | 1 | High when the latch holds a completed sense |

## Verification
The hardest case to reach is the same-edge collision. A write changes a bit of the context that a sense strobe is loading at that very edge, and the outcome depends on ordering inside one cycle. The bench drives the write and the strobe on the same falling edge. It checks that the table which comes out matches the old table. It then issues a second sense to show that the written bit was kept. A second strobe issued during the busy window, with the other context selected, covers the ignore path.

// File: rtl/shadow_lut_pkg.sv
// Package: shared types and constants of the shadow-reconfigurable LUT.
// Assumes: the store always holds exactly two contexts.
package shadow_lut_pkg;
    localparam int unsigned NUM_CTX = 2;

    // Sense sequencer state
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_LOAD = 1'b1
    } sense_state_e;
endpackage

// File: rtl/shadow_lut_store.sv
// Module: background configuration store with two contexts, bit-wide write port.
// Assumes: contents persist across reset (not cleared); the snapshot output is the
// registered content, so a same-edge write is not seen by a load at that edge.
module shadow_lut_store #(
    parameter int unsigned N_IN = 4,
    localparam int unsigned TBL = 1 << N_IN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_ctx,
    input  logic [N_IN-1:0] wr_addr,
    input  logic            wr_bit,
    input  logic            rd_ctx,
    output logic [TBL-1:0]  snap_o
);
    import shadow_lut_pkg::*;

    logic [TBL-1:0] mem [NUM_CTX];

    // One write process per context, each touching only its own table
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_ctx) == c)) begin
                mem[c][wr_addr] <= wr_bit;
            end
        end
    end

    // Snapshot of the selected context, pre-write in the current cycle
    always_comb begin
        snap_o = mem[rd_ctx];
    end

    // R8
    // a write to context 0 leaves context 1 untouched
    ctx_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ctx) |=> $stable(mem[1]));

    // R8
    // a write to context 1 leaves context 0 untouched
    ctx_isolate_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctx) |=> $stable(mem[0]));
endmodule

// File: rtl/shadow_lut_sense.sv
// Module: sense sequencer. Accepts a strobe when idle, issues a one-cycle load,
// then holds valid low for SENSE_CYC cycles in total.
// Assumes: SENSE_CYC >= 1; strobes during the window are dropped.
module shadow_lut_sense #(
    parameter int unsigned SENSE_CYC = 2,
    localparam int unsigned CW = $clog2(SENSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_i,
    output logic load_o,
    output logic valid_o
);
    import shadow_lut_pkg::*;

    sense_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic          valid_q;

    // Accept a strobe only when no sense is running
    assign load_o  = sense_i && (state_q == SQ_IDLE);
    assign valid_o = valid_q;

    // State, window counter and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (load_o) begin
                        state_q <= SQ_LOAD;
                        cnt_q   <= CW'(SENSE_CYC - 1);
                        valid_q <= 1'b0;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        state_q <= SQ_IDLE;
                        valid_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // R5
    // valid is low in the cycle after a load is issued
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !valid_o);

    // R6
    // loads are never issued on consecutive cycles
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // R5
    // valid only rises when a window was running
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(state_q == SQ_LOAD));
endmodule

// File: rtl/shadow_lut_core.sv
// Module: foreground working latch plus multiplexer tree driven by the LUT inputs.
// Assumes: load is a single-cycle pulse; lut_in[0] steers the first tree level.
module shadow_lut_core #(
    parameter int unsigned N_IN = 4,
    localparam int unsigned TBL = 1 << N_IN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TBL-1:0]  snap,
    input  logic [N_IN-1:0] lut_in,
    output logic            lut_o
);
    logic [TBL-1:0] latch_q;
    logic [TBL-1:0] lvl [N_IN+1];

    // Working latch: cleared at reset, replaced whole on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= snap;
        end
    end

    // Multiplexer tree: each level halves the candidates using one input bit
    always_comb begin
        for (int l = 0; l <= N_IN; l++) lvl[l] = '0;
        lvl[0] = latch_q;
        for (int l = 0; l < N_IN; l++) begin
            for (int i = 0; i < (TBL >> (l + 1)); i++) begin
                lvl[l+1][i] = lut_in[l] ? lvl[l][2*i+1] : lvl[l][2*i];
            end
        end
    end

    assign lut_o = lvl[N_IN][0];

    // R3
    // without a load the latch keeps its contents
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(latch_q));

    // R4
    // a load copies the whole store snapshot in one step
    latch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (latch_q == $past(snap)));
endmodule

// File: rtl/shadow_lut.sv
// Module: top of the shadow-reconfigurable LUT. Ties the store, sequencer and
// latch/mux core together.
// Assumes: ctx_sel is sampled with the accepted sense strobe.
module shadow_lut #(
    parameter int unsigned N_IN      = 4,
    parameter int unsigned SENSE_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] lut_in,
    output logic            lut_o,
    input  logic            cfg_we,
    input  logic            cfg_ctx,
    input  logic [N_IN-1:0] cfg_addr,
    input  logic            cfg_data,
    input  logic            ctx_sel,
    input  logic            sense_i,
    output logic            valid_o
);
    localparam int unsigned TBL = 1 << N_IN;

    logic [TBL-1:0] snap;
    logic           load;

    shadow_lut_store #(.N_IN(N_IN)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_ctx  (cfg_ctx),
        .wr_addr (cfg_addr),
        .wr_bit  (cfg_data),
        .rd_ctx  (ctx_sel),
        .snap_o  (snap)
    );

    shadow_lut_sense #(.SENSE_CYC(SENSE_CYC)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_i (sense_i),
        .load_o  (load),
        .valid_o (valid_o)
    );

    shadow_lut_core #(.N_IN(N_IN)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .snap   (snap),
        .lut_in (lut_in),
        .lut_o  (lut_o)
    );

    // R1
    // valid stays low in the first cycle after reset is released
    reset_valid_chk: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> !valid_o);
endmodule

// File: tb/shadow_lut_bench.sv
module shadow_lut_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] lut_in = '0;
    logic       lut_o;
    logic       cfg_we = 1'b0;
    logic       cfg_ctx = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic       cfg_data = 1'b0;
    logic       ctx_sel = 1'b0;
    logic       sense_i = 1'b0;
    logic       valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    shadow_lut u_shadow_lut (
        .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .lut_o(lut_o),
        .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .ctx_sel(ctx_sel), .sense_i(sense_i),
        .valid_o(valid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // sweep all inputs and compare the output with a table
    task automatic check_table(input string req, input logic [15:0] exp);
        logic [15:0] got;
        for (int i = 0; i < 16; i++) begin
            lut_in = 4'(i);
            #1;
            got[i] = lut_o;
        end
        chk(req, {16'h0, got}, {16'h0, exp});
    endtask

    task automatic write_bit(input logic c, input int a, input logic b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctx = c; cfg_addr = 4'(a); cfg_data = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_table(input logic c, input logic [15:0] t);
        for (int a = 0; a < 16; a++) write_bit(c, a, t[a]);
    endtask

    // sense with valid window check (R5)
    task automatic do_sense(input logic c);
        @(negedge clk);
        sense_i = 1'b1; ctx_sel = c;
        @(negedge clk);
        sense_i = 1'b0;
        chk("R5 valid low 1st cycle", {31'h0, valid_o}, 32'h0);
        @(negedge clk);
        chk("R5 valid low 2nd cycle", {31'h0, valid_o}, 32'h0);
        @(negedge clk);
        chk("R5 valid back", {31'h0, valid_o}, 32'h1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'h0, valid_o}, 32'h0);
        check_table("R1 latch cleared", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", {31'h0, valid_o}, 32'h0);
    endtask

    task automatic t_basic;
        write_table(1'b0, 16'hA5C3);
        write_table(1'b1, 16'h3E71);
        check_table("R3 output unchanged by writes", 16'h0000);
        do_sense(1'b0);
        check_table("R2 R4 context 0 loaded", 16'hA5C3);
        do_sense(1'b1);
        check_table("R4 context 1 loaded", 16'h3E71);
        do_sense(1'b0);
        check_table("R8 context 0 intact", 16'hA5C3);
    endtask

    task automatic t_shadow_write;
        write_table(1'b0, 16'h0FF0);
        check_table("R3 shadow write hidden", 16'hA5C3);
        chk("R3 valid kept", {31'h0, valid_o}, 32'h1);
        do_sense(1'b1);
        check_table("R8 context 1 unchanged", 16'h3E71);
        do_sense(1'b0);
        check_table("R4 new table", 16'h0FF0);
    endtask

    task automatic t_busy_strobe;
        @(negedge clk);
        sense_i = 1'b1; ctx_sel = 1'b1;
        @(negedge clk);
        ctx_sel = 1'b0;
        chk("R6 valid low", {31'h0, valid_o}, 32'h0);
        @(negedge clk);
        sense_i = 1'b0;
        chk("R6 still low", {31'h0, valid_o}, 32'h0);
        @(negedge clk);
        chk("R6 valid on first schedule", {31'h0, valid_o}, 32'h1);
        check_table("R6 first context kept", 16'h3E71);
    endtask

    task automatic t_write_during_busy;
        @(negedge clk);
        sense_i = 1'b1; ctx_sel = 1'b0;
        @(negedge clk);
        sense_i = 1'b0;
        cfg_we = 1'b1; cfg_ctx = 1'b0; cfg_addr = 4'd0; cfg_data = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk("R9 valid back", {31'h0, valid_o}, 32'h1);
        check_table("R9 load shows old", 16'h0FF0);
        do_sense(1'b0);
        check_table("R9 busy write stored", 16'h0FF1);
    endtask

    task automatic t_collision;
        @(negedge clk);
        sense_i = 1'b1; ctx_sel = 1'b0;
        cfg_we = 1'b1; cfg_ctx = 1'b0; cfg_addr = 4'd15; cfg_data = 1'b1;
        @(negedge clk);
        sense_i = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 valid", {31'h0, valid_o}, 32'h1);
        check_table("R7 pre-write captured", 16'h0FF1);
        do_sense(1'b0);
        check_table("R7 write landed", 16'h8FF1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_shadow_write();
        t_busy_strobe();
        t_write_during_busy();
        t_collision();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule